// File: doc/BRIEF.md
# Programmable Square-Wave Clock Generator

This block is a 16-bit up-counting timer with automatic reload. Each rollover reloads the counter and flips an output flop, so the output pin carries a square wave with a 50% duty cycle. The counter advances once for every two oscillator-rate enable pulses. With a reload value R, each half period lasts 2 × (65536 − R) enable pulses, and the pin frequency is fosc / (4 × (65536 − R)). With a 16 MHz oscillator this covers about 61 Hz up to 4 MHz.

Software programs the block through a small write port. The port holds a control word (run, count-source select, output enable, flag clear), the 16-bit reload value and a direct load of the counter. The generator runs only when the run bit is set, the count-source select chooses internal timing, and the output enable is set. In that mode rollovers never raise the overflow flag. When the output enable is clear, the pin shows the port latch value. The same counter can still run as a plain auto-reload timer, and in that case it does raise the flag. A one-cycle rollover pulse is brought out so that a serial baud-rate divider can share the rate of the pin.

Top module: `clkgen_top`

## Requirements
- R1: After reset the pin equals `port_latch`, `irq_flag` is 0 and `roll_pulse` is 0.
- R2: While the timer is active, the counter steps on every second `osc_en` pulse. A step from 0xFFFF reloads the counter from the reload register, so the first half period after enabling with counter value C is 2 × (0x10000 − C) pulses.
- R3: In clock-out mode the pin toggles on every rollover. Every half period is 2 × (0x10000 − R) `osc_en` pulses, so high and low times are equal.
- R4: Clock cycles without `osc_en` do not advance the prescaler. With `osc_en` high every other cycle, each half period doubles in clock cycles.
- R5: Rollovers while `out_en` is 1 never set `irq_flag`.
- R6: With run=1, ext_sel=0 and out_en=0, a rollover sets `irq_flag` and the pin keeps `port_latch`. A control write with bit 3 set clears the flag.
- R7: With run=0 or ext_sel=1, the counter holds, `roll_pulse` stays 0 and the pin does not toggle.
- R8: While `out_en` is 0, the pin follows `port_latch` and the toggle flop is held at 1. Setting `out_en` again makes the pin start high.
- R9: `roll_pulse` is high for exactly one cycle per rollover. The number of pulses equals the number of pin transitions in clock-out mode.
- R10: The write map is as follows. Address 0 is control: bit 0 run, bit 1 ext_sel, bit 2 out_en, bit 3 flag clear. Address 1 is reload. Address 2 loads the counter, and a load takes priority over a step in the same cycle. Writes to address 3 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_en | input | 1 | Oscillator-rate clock enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 16 | Write data |
| port_latch | input | 1 | Port latch value shown when output is disabled |
| clk_pin | output | 1 | Pin output |
| roll_pulse | output | 1 | One-cycle rollover pulse |
| irq_flag | output | 1 | Overflow flag (plain timer mode only) |

## Verification
The bench measures the spacing between pin transitions. It uses the largest reload value (a half period of two pulses), a mid value, a long value and a gated `osc_en`. A design with a prescaler that is off by one, or that reloads a cycle late, would show intervals longer by one or two. A design that toggles in only one phase would show unequal halves. The bench also checks the following: that the flag stays low through clock-out rollovers but rises in plain timer mode, that the counter stays frozen under the external-count or stopped settings, and that the pin drops back to the latch value and restarts high. A design that leaked the interrupt, counted with the wrong source, or left the toggle flop low would fail one of these.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;
    typedef enum logic [1:0] {
        REG_CTRL   = 2'd0,
        REG_RELOAD = 2'd1,
        REG_COUNT  = 2'd2,
        REG_SPARE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic out_en;
        logic ext_sel;
        logic run;
    } ctrl_t;

    localparam int CTRL_RUN_BIT  = 0;
    localparam int CTRL_EXT_BIT  = 1;
    localparam int CTRL_OE_BIT   = 2;
    localparam int CTRL_CLR_BIT  = 3;

    function automatic ctrl_t unpack_ctrl(input logic [3:0] bits);
        ctrl_t c;
        c.run     = bits[CTRL_RUN_BIT];
        c.ext_sel = bits[CTRL_EXT_BIT];
        c.out_en  = bits[CTRL_OE_BIT];
        return c;
    endfunction

    function automatic logic timer_active(input ctrl_t c);
        return c.run && !c.ext_sel;
    endfunction
endpackage

// File: rtl/clkgen_regs.sv
module clkgen_regs
    import clkgen_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [1:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic         roll,
    output ctrl_t        ctrl,
    output logic [W-1:0] reload,
    output logic         cnt_wr,
    output logic [W-1:0] cnt_wdata,
    output logic         irq_flag
);
    reg_sel_e sel;
    logic     ctrl_wr;
    logic     clr_req;

    assign sel       = reg_sel_e'(wr_addr);
    assign ctrl_wr   = wr_en && (sel == REG_CTRL);
    assign clr_req   = ctrl_wr && wr_data[CTRL_CLR_BIT];
    assign cnt_wr    = wr_en && (sel == REG_COUNT);
    assign cnt_wdata = wr_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            reload   <= '0;
            irq_flag <= 1'b0;
        end else begin
            if (ctrl_wr)
                ctrl <= unpack_ctrl(wr_data[3:0]);
            if (wr_en && sel == REG_RELOAD)
                reload <= wr_data;
            if (roll && !ctrl.out_en)
                irq_flag <= 1'b1;
            if (clr_req)
                irq_flag <= 1'b0;
        end
    end

    // R5: a clock-out rollover never raises the flag
    assert_no_irq_R5: assert property (@(posedge clk) disable iff (rst)
        (roll && ctrl.out_en && !irq_flag) |=> !irq_flag);
endmodule

// File: rtl/clkgen_core.sv
module clkgen_core #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         osc_en,
    input  logic         active,
    input  logic         cnt_wr,
    input  logic [W-1:0] cnt_wdata,
    input  logic [W-1:0] reload,
    output logic         roll
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic         phase;
    logic [W-1:0] count;
    logic         step;

    assign step = active && osc_en && phase;
    assign roll = step && (count == TOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= 1'b0;
            count <= '0;
        end else begin
            if (!active)
                phase <= 1'b0;
            else if (osc_en)
                phase <= ~phase;
            if (step)
                count <= (count == TOP) ? reload : count + 1'b1;
            if (cnt_wr)
                count <= cnt_wdata;
        end
    end

    // R2: steps are never on back-to-back cycles
    assert_step_spacing_R2: assert property (@(posedge clk) disable iff (rst)
        step |=> !step);
    // R2: rollover reloads
    assert_reload_R2: assert property (@(posedge clk) disable iff (rst)
        (roll && !cnt_wr) |=> count == $past(reload));
    // R7: frozen when inactive
    assert_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        (!active && !cnt_wr) |=> $stable(count));
endmodule

// File: rtl/clkgen_out.sv
module clkgen_out (
    input  logic clk,
    input  logic rst,
    input  logic out_en,
    input  logic roll,
    input  logic port_latch,
    output logic pin
);
    logic tgl;

    always_ff @(posedge clk) begin
        if (rst || !out_en)
            tgl <= 1'b1;
        else if (roll)
            tgl <= ~tgl;
    end

    assign pin = out_en ? tgl : port_latch;

    // R3: each rollover in clock-out mode flips the output
    assert_toggle_R3: assert property (@(posedge clk) disable iff (rst)
        (roll && out_en) |=> (tgl != $past(tgl)));
    // R8: toggle flop restarts high after the output was disabled
    assert_restart_high_R8: assert property (@(posedge clk) disable iff (rst)
        !out_en |=> tgl);
endmodule

// File: rtl/clkgen_top.sv
module clkgen_top
    import clkgen_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         osc_en,
    input  logic         wr_en,
    input  logic [1:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic         port_latch,
    output logic         clk_pin,
    output logic         roll_pulse,
    output logic         irq_flag
);
    ctrl_t        ctrl;
    logic [W-1:0] reload;
    logic         cnt_wr;
    logic [W-1:0] cnt_wdata;
    logic         roll;

    clkgen_regs #(.W(W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .roll(roll), .ctrl(ctrl), .reload(reload),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .irq_flag(irq_flag)
    );

    clkgen_core #(.W(W)) u_core (
        .clk(clk), .rst(rst), .osc_en(osc_en), .active(timer_active(ctrl)),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .reload(reload), .roll(roll)
    );

    clkgen_out u_out (
        .clk(clk), .rst(rst), .out_en(ctrl.out_en), .roll(roll),
        .port_latch(port_latch), .pin(clk_pin)
    );

    assign roll_pulse = roll;

    // R9: one-cycle pulse per rollover
    assert_pulse_width_R9: assert property (@(posedge clk) disable iff (rst)
        roll_pulse |=> !roll_pulse);
endmodule

// File: tb/test_clkgen_top.sv
module test_clkgen_top;
    logic        clk = 0;
    logic        rst = 1;
    logic        osc_en = 1;
    logic        wr_en = 0;
    logic [1:0]  wr_addr = 0;
    logic [15:0] wr_data = 0;
    logic        port_latch = 1;
    logic        clk_pin, roll_pulse, irq_flag;

    int tests = 0, fails = 0;
    int cyc = 0;
    int mon_ref = 0;
    int rolls = 0, flips = 0;
    bit mon_on = 0, gate = 0, done = 0;
    logic last_pin = 1;
    int exp_q[$];

    always #2.5 clk = ~clk;

    clkgen_top i_clkgen_top (
        .clk(clk), .rst(rst), .osc_en(osc_en), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .port_latch(port_latch), .clk_pin(clk_pin),
        .roll_pulse(roll_pulse), .irq_flag(irq_flag)
    );

    always @(posedge clk) cyc++;

    always @(negedge clk) osc_en = gate ? ~osc_en : 1'b1;

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // monitor: pops expected half-period lengths (-1 = do not compare)
    always @(negedge clk) begin
        if (roll_pulse) rolls++;
        if (clk_pin !== last_pin) begin
            flips++;
            if (mon_on && exp_q.size() > 0) begin
                int e;
                e = exp_q.pop_front();
                if (e >= 0) check("R2/R3 half-period", cyc - mon_ref, e);
                mon_ref = cyc;
                if (exp_q.size() == 0) mon_on = 0;
            end
        end
        last_pin = clk_pin;
    end

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic start(input logic [15:0] d);
        wr(2'd0, d);
        mon_ref = cyc;
        mon_on = 1;
    endtask

    task automatic drain(input string req);
        int n = 0;
        while (exp_q.size() > 0 && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check(req, exp_q.size(), 0);
        exp_q.delete();
        mon_on = 0;
    endtask

    initial begin
        int r0, f0;
        repeat (3) @(negedge clk);
        check("R1 pin=latch", clk_pin, 1);
        port_latch = 0;
        #1;
        check("R1 pin=latch low", clk_pin, 0);
        check("R1 irq", irq_flag, 0);
        check("R1 roll", roll_pulse, 0);
        rst = 0;
        port_latch = 1;
        @(negedge clk);

        // R2 R3 R5 R9: reload FFF0, start count FFF8
        wr(2'd1, 16'hFFF0);
        wr(2'd2, 16'hFFF8);
        r0 = rolls; f0 = flips;
        exp_q = '{16, 32, 32, 32, 32};
        start(16'h0005);
        drain("R3 sequence done");
        check("R5 no irq in clock-out", irq_flag, 0);
        check("R9 rolls==flips", rolls - r0, flips - f0);
        wr(2'd0, 16'h0000);

        // R3 R10: max rate, spare address write ignored
        wr(2'd1, 16'hFFFF);
        wr(2'd2, 16'hFFFF);
        wr(2'd3, 16'h1234);
        exp_q = '{2, 2, 2, 2};
        start(16'h0005);
        drain("R10 spare ignored, R3 max rate");
        wr(2'd0, 16'h0000);

        // R3: long half period
        wr(2'd1, 16'hFF00);
        wr(2'd2, 16'hFF00);
        exp_q = '{512, 512};
        start(16'h0005);
        drain("R3 long period");
        wr(2'd0, 16'h0000);

        // R4: gated enable doubles
        wr(2'd1, 16'hFFF0);
        wr(2'd2, 16'hFFF0);
        gate = 1;
        exp_q = '{-1, 64, 64};
        start(16'h0005);
        drain("R4 gated enable");
        wr(2'd0, 16'h0000);
        gate = 0;

        // R6: plain timer mode sets the flag
        port_latch = 0;
        wr(2'd2, 16'hFFFC);
        f0 = flips;
        wr(2'd0, 16'h0001);
        repeat (20) @(negedge clk);
        check("R6 flag set", irq_flag, 1);
        check("R6 pin=latch", clk_pin, 0);
        check("R6 no pin flips", flips - f0, 0);
        wr(2'd0, 16'h0008);
        check("R6 flag cleared", irq_flag, 0);
        port_latch = 1;
        @(negedge clk);

        // R7: external select and stopped both freeze
        wr(2'd2, 16'hFFFE);
        r0 = rolls; f0 = flips;
        wr(2'd0, 16'h0007);
        repeat (40) @(negedge clk);
        check("R7 ext_sel no rolls", rolls - r0, 0);
        check("R7 ext_sel no flips", flips - f0, 0);
        wr(2'd0, 16'h0004);
        repeat (40) @(negedge clk);
        check("R7 stopped no rolls", rolls - r0, 0);
        check("R7 pin high", clk_pin, 1);
        wr(2'd0, 16'h0000);

        // R8: disable returns to latch, re-enable starts high
        wr(2'd1, 16'hFFF0);
        wr(2'd2, 16'hFFF0);
        wr(2'd0, 16'h0005);
        repeat (39) @(negedge clk);
        check("R3 low half", clk_pin, 0);
        wr(2'd0, 16'h0001);
        check("R8 pin=latch 1", clk_pin, 1);
        port_latch = 0;
        #1;
        check("R8 pin=latch 0", clk_pin, 0);
        wr(2'd0, 16'h0005);
        check("R8 restart high", clk_pin, 1);
        wr(2'd0, 16'h0000);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule